// File: doc/BRIEF.md
# Half-Duplex Synchronous Programming-Link Master

This block drives a two-wire programming link toward a target device: a clock output that the master alone generates, and a single data line that master and target share in turn. On request it puts the target into programming mode. It offers two entry variants. In the first, the clock is held high and the data line low for a timed interval, and then data is raised. In the second, a separate active-low reset output is pulled low and held there for the whole session. After either entry, the master clocks out two all-high idle frames, which give the target the run of idle bits it needs before traffic.

Once the link is up, a host exchanges single bytes with the block. Transmit uses a valid/ready handshake. Receive is started by a one-cycle request and ends with a one-cycle done strobe, which carries the byte, a frame-error flag and a timeout flag. Each byte travels as a twelve-bit synchronous frame: a low start bit, eight data bits with the least-significant bit first, an even-parity bit and two high stop bits. The master changes data on the falling edge of the link clock and samples on the rising edge. The block guards every change of direction on the shared line. An exit request is honoured only between frames, and it releases every pin to high impedance. The link rate comes from a divider input: one bit period lasts 2·(N+1) system cycles.

Top module: `plinkMaster`

## Requirements
- R1: After reset the block is inactive: linkActive, linkClkOe, dataOe, tgtRstOe and txReady are all low.
- R2: With entryMode=0, an enter request drives linkClk high and holds dataOut low with dataOe high for exactly HOLD_CYCLES system cycles. Data is then driven high while the clock is still held high, and the clock does not toggle until SETTLE_CYCLES later.
- R3: With entryMode=1, tgtRstOe goes high with tgtRstN low from the enter request onward. It stays that way, unchanged, through all traffic until the session is exited.
- R4: After entry the master emits 24 link-clock falling edges with the data line driven high, which makes two idle frames. txReady rises together with the 24th falling edge.
- R5: While the link is active, linkClk has a period of 2·(divider+1) system cycles.
- R6: A transmitted byte appears on dataOut as a start bit 0, then data bits 0 to 7, then an even-parity bit (the XOR of the data), then two stop bits of 1. Bits change on linkClk falling edges and are stable at rising edges.
- R7: When turning from transmit to receive, dataOe stays high through both stop bits of the last frame. It is low once a receive request has been accepted.
- R8: When turning from receive to transmit, the master waits at least two linkClk falling edges (one full clock cycle) after the transmit request. It then takes the line, driving it high. The target and the master never drive the line at the same time.
- R9: In receive, the first rising-edge sample of 0 is the start bit. The next 11 rising-edge samples are data bits 0 to 7, then parity, then two stops. rxDone pulses for one cycle with rxData equal to the data bits and rxFrameErr low when the frame is well formed.
- R10: rxFrameErr is high with rxDone when the received parity is not even over data plus parity, or when either stop bit is 0.
- R11: If no start bit arrives within TMO_CYCLES system cycles of an accepted receive request, rxDone pulses with rxTimeout high exactly TMO_CYCLES cycles after acceptance.
- R12: An exit request made during a frame takes effect only after that frame's second stop bit has been shifted out. Then linkActive, linkClkOe, dataOe and tgtRstOe all go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divider | input | DIV_W | Link rate divider N; bit period is 2·(N+1) cycles |
| entryMode | input | 1 | 0: clock/data entry, 1: separate reset-pin entry |
| enterReq | input | 1 | Start a session (sampled while inactive) |
| exitReq | input | 1 | End the session at the next frame boundary |
| txValid | input | 1 | Host offers a byte to transmit |
| txData | input | 8 | Byte to transmit |
| txReady | output | 1 | Byte accepted on txValid and txReady |
| rxReq | input | 1 | Start receiving one frame |
| rxDone | output | 1 | One-cycle strobe: receive finished |
| rxData | output | 8 | Received byte, held until the next receive |
| rxFrameErr | output | 1 | Parity or stop-bit error in the received frame |
| rxTimeout | output | 1 | Receive ended without a start bit |
| linkActive | output | 1 | Session in progress |
| linkClk | output | 1 | Link clock value |
| linkClkOe | output | 1 | Link clock output enable |
| dataOut | output | 1 | Data line value when driven |
| dataOe | output | 1 | Data line output enable |
| dataIn | input | 1 | Data line as seen at the pad (pulled high) |
| tgtRstN | output | 1 | Target reset value, low while driven |
| tgtRstOe | output | 1 | Target reset output enable |

## Verification
A table of mixed transmit and receive bytes is walked in order. It covers all-zero, all-one, single-bit and alternating patterns. The parity-0 and parity-1 cases separate a correct parity computation from a constant one, and the single-bit bytes expose bit-order mistakes. The table sequence contains every direction change (transmit to transmit, transmit to receive, receive to transmit, receive to receive), so the turnaround guards and the bench's contention monitor are exercised on every kind of transition. Receive frames with a corrupted parity bit and with a low stop bit are told apart from good frames by the error flag. Two entry sessions with different modes and divider values distinguish the entry timing, the reset-pin holding and the rate formula at divider zero and at a non-zero divider.

// File: rtl/plinkPkg.sv
package plinkPkg;
  localparam int FRAME_BITS = 12;  // start + 8 data + parity + 2 stop
  localparam int RX_SAMPLES = 11;  // samples after the start bit

  typedef enum logic [3:0] {
    S_OFF, S_HOLD, S_SETTLE, S_IDLE, S_READY, S_TX, S_TURN, S_RXWAIT, S_RXBITS
  } plinkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clkRun;     // divider running, link clock toggling
    logic loadTx;     // capture txByte into the frame shifter
    logic shiftTx;    // present next frame bit (falling edge)
    logic driveLow;   // force data output low (entry hold)
    logic driveHigh;  // force data output high
    logic shiftRx;    // capture a received bit (rising edge)
    logic tmoRun;     // receive timeout counter running
  } plinkStrobe_t;
endpackage

// File: rtl/plinkDatapath.sv
module plinkDatapath
  import plinkPkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int TMO_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  input  plinkStrobe_t     stb,
  input  logic [7:0]       txByte,
  input  logic             dataIn,
  output logic             fallTick,
  output logic             riseTick,
  output logic             linkClk,
  output logic             txBit,
  output logic [7:0]       rxByte,
  output logic             rxErr,
  output logic             tmoHit
);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);

  logic [DIV_W-1:0]            divCnt;
  logic                        clkReg;
  logic                        tick;
  logic [FRAME_BITS-1:0]       txShift;
  logic [RX_SAMPLES-1:0]       rxShift;
  logic [TMO_W-1:0]            tmoCnt;

  // rate generator: half period of divider+1 cycles
  always_ff @(posedge clk) begin
    if (!rstN || !stb.clkRun) begin
      divCnt <= '0;
      clkReg <= 1'b1;
    end else if (divCnt == divider) begin
      divCnt <= '0;
      clkReg <= ~clkReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick     = stb.clkRun && (divCnt == divider);
  assign fallTick = tick && clkReg;
  assign riseTick = tick && !clkReg;
  assign linkClk  = clkReg;

  // transmit shifter, refilled with ones so idle bits come for free
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
      txBit   <= 1'b1;
    end else begin
      if (stb.loadTx) begin
        txShift <= {2'b11, ^txByte, txByte, 1'b0};
      end else if (stb.shiftTx) begin
        txBit   <= txShift[0];
        txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
      end
      if (stb.driveLow)       txBit <= 1'b0;
      else if (stb.driveHigh) txBit <= 1'b1;
    end
  end

  // receive shifter, LSB arrives first
  always_ff @(posedge clk) begin
    if (!rstN)            rxShift <= '0;
    else if (stb.shiftRx) rxShift <= {dataIn, rxShift[RX_SAMPLES-1:1]};
  end

  assign rxByte = rxShift[7:0];
  assign rxErr  = (^rxShift[8:0]) | ~(rxShift[9] & rxShift[10]);

  // start-bit timeout
  always_ff @(posedge clk) begin
    if (!rstN || !stb.tmoRun) tmoCnt <= '0;
    else                      tmoCnt <= tmoCnt + 1'b1;
  end

  assign tmoHit = stb.tmoRun && (tmoCnt == TMO_W'(TMO_CYCLES - 1));

  // control may only move transmit data on a falling link edge
  assert_shift_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftTx |-> fallTick);

  // control may only sample received data on a rising link edge
  assert_sample_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftRx |-> riseTick);
endmodule

// File: rtl/plinkControl.sv
module plinkControl
  import plinkPkg::*;
#(
  parameter int HOLD_CYCLES   = 16,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enterReq,
  input  logic         entryMode,
  input  logic         exitReq,
  input  logic         txValid,
  input  logic         rxReq,
  input  logic         fallTick,
  input  logic         riseTick,
  input  logic         dataIn,
  input  logic         tmoHit,
  output plinkStrobe_t stb,
  output logic         txReady,
  output logic         rxDone,
  output logic         rxTimeout,
  output logic         active,
  output logic         dataOe,
  output logic         rstOe
);
  localparam int WAIT_MAX  = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
  localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
  localparam int CNT_W     = $clog2(2 * FRAME_BITS);
  localparam int IDLE_LAST = 2 * FRAME_BITS - 1;

  plinkState_t     state;
  logic            modeRst;
  logic            dirTx;
  logic [WAIT_W-1:0] waitCnt;
  logic [CNT_W-1:0]  bitCnt;

  always_comb begin
    stb           = '0;
    stb.clkRun    = !(state inside {S_OFF, S_HOLD, S_SETTLE});
    stb.driveLow  = (state == S_HOLD) && !modeRst;
    stb.driveHigh = (state == S_SETTLE) || ((state == S_HOLD) && modeRst) ||
                    ((state == S_TURN) && fallTick && bitCnt == CNT_W'(1));
    stb.loadTx    = (state == S_READY) && !exitReq && txValid && dirTx;
    stb.shiftTx   = fallTick && ((state == S_IDLE) ||
                    ((state == S_TX) && bitCnt != CNT_W'(FRAME_BITS)));
    stb.shiftRx   = (state == S_RXBITS) && riseTick;
    stb.tmoRun    = (state == S_RXWAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_OFF;
      modeRst   <= 1'b0;
      dirTx     <= 1'b0;
      waitCnt   <= '0;
      bitCnt    <= '0;
      rxDone    <= 1'b0;
      rxTimeout <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      unique case (state)
        S_OFF: if (enterReq) begin
          modeRst <= entryMode;
          dirTx   <= 1'b1;
          waitCnt <= '0;
          state   <= S_HOLD;
        end
        S_HOLD: if (waitCnt == WAIT_W'(HOLD_CYCLES - 1)) begin
          waitCnt <= '0;
          state   <= S_SETTLE;
        end else waitCnt <= waitCnt + 1'b1;
        S_SETTLE: if (waitCnt == WAIT_W'(SETTLE_CYCLES - 1)) begin
          bitCnt <= '0;
          state  <= S_IDLE;
        end else waitCnt <= waitCnt + 1'b1;
        S_IDLE: if (fallTick) begin
          if (bitCnt == CNT_W'(IDLE_LAST)) state <= S_READY;
          else bitCnt <= bitCnt + 1'b1;
        end
        S_READY: begin
          bitCnt <= '0;
          if (exitReq) begin
            dirTx <= 1'b0;
            state <= S_OFF;
          end else if (txValid) begin
            state <= dirTx ? S_TX : S_TURN;
          end else if (rxReq) begin
            dirTx     <= 1'b0;
            rxTimeout <= 1'b0;
            state     <= S_RXWAIT;
          end
        end
        S_TX: if (fallTick) begin
          if (bitCnt == CNT_W'(FRAME_BITS)) state <= S_READY;
          else bitCnt <= bitCnt + 1'b1;
        end
        S_TURN: if (fallTick) begin
          if (bitCnt == CNT_W'(1)) begin
            dirTx <= 1'b1;
            state <= S_READY;
          end else bitCnt <= bitCnt + 1'b1;
        end
        S_RXWAIT: if (tmoHit) begin
          rxDone    <= 1'b1;
          rxTimeout <= 1'b1;
          state     <= S_READY;
        end else if (riseTick && !dataIn) begin
          bitCnt <= '0;
          state  <= S_RXBITS;
        end
        S_RXBITS: if (riseTick) begin
          if (bitCnt == CNT_W'(RX_SAMPLES - 1)) begin
            rxDone <= 1'b1;
            state  <= S_READY;
          end else bitCnt <= bitCnt + 1'b1;
        end
        default: state <= S_OFF;
      endcase
    end
  end

  assign active  = (state != S_OFF);
  assign dataOe  = active && dirTx;
  assign rstOe   = active && modeRst;
  assign txReady = (state == S_READY) && dirTx && !exitReq;

  assert_tx_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX) |-> (bitCnt <= CNT_W'(FRAME_BITS)));

  // the line is released only at a frame boundary
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirTx) |-> ($past(state) == S_READY));

  // ownership is taken back only by the turnaround wait, on a falling edge
  assert_take_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dirTx) && $past(state) != S_OFF) |-> ($past(state) == S_TURN && $past(fallTick)));

  assert_rst_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(rstOe));

  assert_timeout_src_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxTimeout) |-> ($past(state) == S_RXWAIT));

  assert_exit_boundary_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> ($past(state) == S_READY));
endmodule

// File: rtl/plinkMaster.sv
module plinkMaster
  import plinkPkg::*;
#(
  parameter int DIV_W         = 8,
  parameter int HOLD_CYCLES   = 16,
  parameter int SETTLE_CYCLES = 64,
  parameter int TMO_CYCLES    = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  input  logic             entryMode,
  input  logic             enterReq,
  input  logic             exitReq,
  input  logic             txValid,
  input  logic [7:0]       txData,
  output logic             txReady,
  input  logic             rxReq,
  output logic             rxDone,
  output logic [7:0]       rxData,
  output logic             rxFrameErr,
  output logic             rxTimeout,
  output logic             linkActive,
  output logic             linkClk,
  output logic             linkClkOe,
  output logic             dataOut,
  output logic             dataOe,
  input  logic             dataIn,
  output logic             tgtRstN,
  output logic             tgtRstOe
);
  plinkStrobe_t stb;
  logic fallTick, riseTick, tmoHit, active, rstOe;

  plinkControl #(
    .HOLD_CYCLES  (HOLD_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enterReq (enterReq),
    .entryMode(entryMode),
    .exitReq  (exitReq),
    .txValid  (txValid),
    .rxReq    (rxReq),
    .fallTick (fallTick),
    .riseTick (riseTick),
    .dataIn   (dataIn),
    .tmoHit   (tmoHit),
    .stb      (stb),
    .txReady  (txReady),
    .rxDone   (rxDone),
    .rxTimeout(rxTimeout),
    .active   (active),
    .dataOe   (dataOe),
    .rstOe    (rstOe)
  );

  plinkDatapath #(
    .DIV_W     (DIV_W),
    .TMO_CYCLES(TMO_CYCLES)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .divider (divider),
    .stb     (stb),
    .txByte  (txData),
    .dataIn  (dataIn),
    .fallTick(fallTick),
    .riseTick(riseTick),
    .linkClk (linkClk),
    .txBit   (dataOut),
    .rxByte  (rxData),
    .rxErr   (rxFrameErr),
    .tmoHit  (tmoHit)
  );

  assign linkActive = active;
  assign linkClkOe  = active;
  assign tgtRstOe   = rstOe;
  assign tgtRstN    = ~rstOe;
endmodule

// File: tb/sim_plinkMaster.sv
module sim_plinkMaster;
  localparam int HOLD   = 6;
  localparam int SETTLE = 8;
  localparam int TMO    = 120;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic [7:0] divider = 8'd2;
  logic       entryMode = 1'b0, enterReq = 1'b0, exitReq = 1'b0;
  logic       txValid = 1'b0, rxReq = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txReady, rxDone, rxFrameErr, rxTimeout, linkActive;
  logic [7:0] rxData;
  logic       linkClk, linkClkOe, dataOut, dataOe, dataIn, tgtRstN, tgtRstOe;
  logic       tgtDrv = 1'b0, tgtBit = 1'b1;

  assign dataIn = dataOe ? dataOut : (tgtDrv ? tgtBit : 1'b1);

  plinkMaster #(.DIV_W(8), .HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rstN(rstN), .divider(divider), .entryMode(entryMode), .enterReq(enterReq),
    .exitReq(exitReq), .txValid(txValid), .txData(txData), .txReady(txReady), .rxReq(rxReq),
    .rxDone(rxDone), .rxData(rxData), .rxFrameErr(rxFrameErr), .rxTimeout(rxTimeout),
    .linkActive(linkActive), .linkClk(linkClk), .linkClkOe(linkClkOe), .dataOut(dataOut),
    .dataOe(dataOe), .dataIn(dataIn), .tgtRstN(tgtRstN), .tgtRstOe(tgtRstOe));

  int total = 0, bad = 0, clash = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) if (dataOe && tgtDrv) clash++;

  // {isRx, data, expected parity, corrupt parity, low stop, expected error}
  localparam logic [12:0] VEC [9] = '{
    {1'b0, 8'h00, 4'b0000}, {1'b0, 8'hA5, 4'b0000}, {1'b1, 8'h3C, 4'b0000},
    {1'b0, 8'h01, 4'b1000}, {1'b1, 8'hC3, 4'b0101}, {1'b1, 8'h5A, 4'b0011},
    {1'b0, 8'h80, 4'b1000}, {1'b0, 8'hFF, 4'b0000}, {1'b1, 8'h7E, 4'b0000}
  };

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    txValid = 1'b1; txData = b;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic captureFrame(output logic [11:0] bits, output bit oeOk);
    oeOk = 1'b1; bits = '1;
    do @(posedge linkClk); while (!(dataOe && !dataOut));
    bits[0] = 1'b0;
    for (int i = 1; i < 12; i++) begin
      @(posedge linkClk);
      bits[i] = dataOut;
      if (!dataOe) oeOk = 1'b0;
    end
  endtask

  task automatic txCheck(input logic [7:0] b, input logic expPar, input string tag);
    logic [11:0] bits; bit oeOk;
    fork
      sendByte(b);
      captureFrame(bits, oeOk);
    join
    check(bits[8:1] == b, "R6", {tag, " data bits LSB first"}, bits[8:1], b);
    check(bits[9] == expPar, "R6", {tag, " even parity"}, bits[9], expPar);
    check(bits[11:10] == 2'b11 && oeOk, "R7", {tag, " stop bits driven"}, {oeOk, bits[11:10]}, 7);
  endtask

  task automatic targetSend(input logic [7:0] b, input logic badPar, input logic badStop);
    @(negedge linkClk); tgtDrv = 1'b1; tgtBit = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge linkClk); tgtBit = b[i]; end
    @(negedge linkClk); tgtBit = (^b) ^ badPar;
    @(negedge linkClk); tgtBit = ~badStop;
    @(negedge linkClk); tgtBit = 1'b1;
    @(negedge linkClk); tgtDrv = 1'b0;
  endtask

  task automatic rxCheck(input logic [7:0] b, input logic badPar, input logic badStop, input logic expErr);
    logic [7:0] gotData; logic gotErr, gotTmo;
    repeat (3) @(negedge linkClk);
    @(negedge clk) rxReq = 1'b1;
    @(negedge clk) rxReq = 1'b0;
    check(!dataOe, "R7", "line released after receive request", dataOe, 0);
    fork
      targetSend(b, badPar, badStop);
      begin
        do @(negedge clk); while (!rxDone);
        gotData = rxData; gotErr = rxFrameErr; gotTmo = rxTimeout;
      end
    join
    check(gotData == b, "R9", "received byte", gotData, b);
    check(gotErr == expErr, expErr ? "R10" : "R9", "frame error flag", gotErr, expErr);
    check(!gotTmo, "R9", "no timeout on arriving frame", gotTmo, 0);
  endtask

  task automatic measurePeriod(input int exp, input string tag);
    logic prev; int n; int rises;
    prev = linkClk; n = 0; rises = 0;
    while (rises < 2) begin
      @(negedge clk);
      if (rises == 1) n++;
      if (!prev && linkClk) rises++;
      prev = linkClk;
    end
    check(n == exp, "R5", {tag, " link clock period"}, n, exp);
  endtask

  initial begin
    int lowCnt, falls; bit clkBad, idleBad; logic prev;
    logic [11:0] bits; bit oeOk;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!linkActive && !linkClkOe && !dataOe && !tgtRstOe && !txReady, "R1", "idle after reset",
          {linkActive, linkClkOe, dataOe, tgtRstOe, txReady}, 0);

    // session 1: clock/data entry, divider 2
    entryMode = 1'b0; enterReq = 1'b1;
    @(negedge clk) enterReq = 1'b0;
    check(linkActive && linkClkOe && dataOe && !tgtRstOe, "R2", "pins driven, reset pin untouched",
          {linkActive, linkClkOe, dataOe, tgtRstOe}, 14);
    lowCnt = 0; clkBad = 0;
    for (int i = 0; i < 200; i++) begin
      if (!dataOut) begin
        lowCnt++;
        if (!linkClk) clkBad = 1;
      end else if (lowCnt > 0) break;
      @(negedge clk);
    end
    check(lowCnt == HOLD, "R2", "data low hold length", lowCnt, HOLD);
    check(!clkBad && linkClk, "R2", "clock high during hold and after data rise", clkBad, 0);
    falls = 0; idleBad = 0; prev = linkClk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (prev && !linkClk) falls++;
      prev = linkClk;
      if (!dataOut || !dataOe) idleBad = 1;
      if (txReady) break;
    end
    check(falls == 24, "R4", "idle falling edges before ready", falls, 24);
    check(!idleBad, "R4", "data high through idle frames", idleBad, 0);
    measurePeriod(6, "divider 2");

    // table walk: all direction changes
    for (int k = 0; k < 9; k++) begin
      if (VEC[k][12]) rxCheck(VEC[k][11:4], VEC[k][2], VEC[k][1], VEC[k][0]);
      else txCheck(VEC[k][11:4], VEC[k][3], $sformatf("vec%0d", k));
    end

    // R8 receive-to-transmit turnaround after a receive
    rxCheck(8'h69, 1'b0, 1'b0, 1'b0);
    fork
      captureFrame(bits, oeOk);
      begin
        @(negedge clk);
        txValid = 1'b1; txData = 8'h2D;
        falls = 0; prev = linkClk;
        while (!dataOe) begin
          @(negedge clk);
          if (prev && !linkClk) falls++;
          prev = linkClk;
        end
        check(falls >= 2 && falls <= 3, "R8", "falling edges before taking line", falls, 2);
        check(dataOut, "R8", "line driven high at takeover", dataOut, 1);
        while (!txReady) @(negedge clk);
        @(negedge clk);
        txValid = 1'b0;
      end
    join
    check(bits[8:1] == 8'h2D && bits[9] == 1'b0, "R8", "frame after turnaround", bits[9:1], 9'h02D);

    // R11 timeout with a silent target
    repeat (3) @(negedge linkClk);
    @(negedge clk) rxReq = 1'b1;
    @(negedge clk) rxReq = 1'b0;
    falls = 1;
    while (!rxDone && falls < 5000) begin @(negedge clk); falls++; end
    check(falls == TMO + 1, "R11", "timeout delay", falls, TMO + 1);
    check(rxTimeout, "R11", "timeout flag", rxTimeout, 1);

    // R12 exit requested during a frame
    fork
      captureFrame(bits, oeOk);
      begin
        sendByte(8'h96);
        exitReq = 1'b1;
      end
    join
    check(oeOk && bits[11:10] == 2'b11 && bits[8:1] == 8'h96, "R12", "frame completed before exit",
          {oeOk, bits[11:10]}, 7);
    for (int i = 0; i < 100 && linkActive; i++) @(negedge clk);
    exitReq = 1'b0;
    check(!linkActive && !linkClkOe && !dataOe && !tgtRstOe, "R12", "pins released",
          {linkActive, linkClkOe, dataOe, tgtRstOe}, 0);

    // session 2: reset-pin entry, divider 0
    divider = 8'd0; entryMode = 1'b1;
    @(negedge clk) enterReq = 1'b1;
    @(negedge clk) enterReq = 1'b0;
    check(tgtRstOe && !tgtRstN, "R3", "reset pin driven low at entry", {tgtRstOe, tgtRstN}, 2);
    for (int i = 0; i < 2000 && !txReady; i++) @(negedge clk);
    measurePeriod(2, "divider 0");
    txCheck(8'h5C, 1'b0, "rst-mode");
    check(tgtRstOe && !tgtRstN, "R3", "reset pin held during traffic", {tgtRstOe, tgtRstN}, 2);
    @(negedge clk) exitReq = 1'b1;
    for (int i = 0; i < 100 && linkActive; i++) @(negedge clk);
    exitReq = 1'b0;
    check(!tgtRstOe && !linkActive, "R3", "reset pin released on exit", {tgtRstOe, linkActive}, 0);
    check(clash == 0, "R8", "no drive contention", clash, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule